// File: doc/BRIEF.md
# Interval Operation Sampler

This block watches a stream of operation-issue strobes and, at a programmable spacing counted in issued operations, picks one of them for profiling. It follows the picked operation until a completion strobe with the same identifier arrives. It then emits a one-cycle record that carries the operation's identifier and its total latency in cycles, measured from the cycle of selection. A downstream filter takes that record.

Only one picked operation may be outstanding at a time. When the spacing counter runs out while an earlier pick is still open, the new pick is thrown away and a saturating 32-bit collision counter goes up by one. This count is taken before any downstream filtering. The spacing can be perturbed on every reload by the low bits of a free-standing 16-bit LFSR, so that the sampling does not lock onto periodic code. A programmed spacing of zero falls back to a fixed minimum.

Top module: `interval_sampler`

## Requirements
- R1: After reset, smp_vld is 0, coll_cnt is 0 and no operation is outstanding. The countdown starts at MIN_INTERVAL (default 16), so the 16th issue after reset is the first one picked, whatever cfg_interval holds.
- R2: Each issue decrements the countdown. The issue that finds the countdown at 1 or below is picked, and the countdown is reloaded at that moment from the current configuration. With jitter off and cfg_interval = N (N > 0), picks after the first fall on every Nth issue.
- R3: When cfg_interval is 0, the reload base is MIN_INTERVAL (16).
- R4: With cfg_jitter_en = 1, each reload adds the low 8 bits of a 16-bit LFSR to the base. The LFSR is seeded with 0xACE1 at reset and shifts left on every pick, dropped picks included; the new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10. A reload uses the LFSR value from before that shift.
- R5: At most one picked operation is outstanding. A completion whose done_id differs from the picked ID, or one that arrives while nothing is outstanding, has no effect.
- R6: A pick that lands while an operation is outstanding is dropped and increments coll_cnt by one. This holds even when the outstanding operation completes in that same cycle.
- R7: A completion with the picked ID in cycle C, for a pick made in cycle S, makes smp_vld high for exactly one cycle, the cycle after C. In that cycle smp_id is the picked ID and smp_lat is C - S.
- R8: smp_lat saturates at 0xFFFF instead of wrapping.
- R9: coll_cnt saturates at its maximum. coll_clr sets it to 0 on the next edge and takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An operation issues this cycle |
| issue_id | input | ID_W (8) | Identifier of the issuing operation |
| done_vld | input | 1 | An operation completes this cycle |
| done_id | input | ID_W (8) | Identifier of the completing operation |
| cfg_interval | input | CNT_W (16) | Sampling spacing in operations; 0 selects the minimum |
| cfg_jitter_en | input | 1 | Add LFSR perturbation to each reload |
| coll_clr | input | 1 | Synchronous clear of the collision counter |
| smp_vld | output | 1 | One-cycle completed-sample strobe |
| smp_id | output | ID_W (8) | Identifier of the completed sample |
| smp_lat | output | LAT_W (16) | Latency of the completed sample in cycles |
| coll_cnt | output | COLL_W (32) | Count of dropped picks |

## Verification
The assertions assume that a completion for the picked ID arrives at most once per pick, and that identifiers issued close together are distinct enough for a completion to refer to the right operation. The stimulus issues IDs from a running counter. It sends the picked ID as a completion only while a pick is open in the bench's own model, and otherwise sends IDs that do not match. Random phases vary the spacing between 0 and 6, toggle jitter, and raise coll_clr rarely, so that collisions, clears and back-to-back picks all occur. Directed runs cover the spacings that follow reset, a dropped pick in the same cycle as its predecessor's completion, and latency saturation.

// File: rtl/isam_pkg.sv
// Shared constants and the LFSR step function for the interval sampler.
// Assumes a 16-bit maximal-length Fibonacci register (taps 16,14,13,11).
package isam_pkg;
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;

    // One left shift of the perturbation register
    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/isam_lfsr.sv
// Perturbation source: a 16-bit LFSR that shifts once per step request.
// Assumes step is a single-cycle qualifier; the state is never all-zero.
module isam_lfsr
    import isam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] state
);
    // Advance on every pick, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= LFSR_SEED;
        else if (step) state <= lfsr_next(state);
    end
endmodule

// File: rtl/isam_countdown.sv
// Issue countdown: decrements once per issued operation and flags the
// issue that finds the count at 1 or below as the pick, reloading the
// count from the configured base plus optional jitter at that moment.
// Assumes JIT_W <= 16 and MIN_INTERVAL > 0.
module isam_countdown #(
    parameter int CNT_W        = 16,
    parameter int JIT_W        = 8,
    parameter int MIN_INTERVAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             cfg_jitter_en,
    input  logic [JIT_W-1:0] jitter,
    output logic             pick
);
    localparam int RW = ((CNT_W > JIT_W) ? CNT_W : JIT_W) + 1;

    logic [RW-1:0] remain;
    logic [RW-1:0] base;
    logic [RW-1:0] reload;

    // Reload value: programmed base or minimum, plus jitter when enabled
    always_comb begin
        base   = (cfg_interval == '0) ? RW'(MIN_INTERVAL)
                                      : {{(RW-CNT_W){1'b0}}, cfg_interval};
        reload = base + (cfg_jitter_en ? {{(RW-JIT_W){1'b0}}, jitter} : '0);
    end

    assign pick = issue_vld && (remain <= RW'(1));

    // Count issues down, reload on a pick
    always_ff @(posedge clk) begin
        if (!rst_n)         remain <= RW'(MIN_INTERVAL);
        else if (pick)      remain <= reload;
        else if (issue_vld) remain <= remain - RW'(1);
    end
endmodule

// File: rtl/isam_tracker.sv
// Single-slot tracker: accepts a pick when idle, measures its latency in
// saturating cycles and emits a one-cycle record when its completion
// arrives. A pick while busy is reported as a drop.
// Assumes only the picked ID completes once per pick.
module isam_tracker #(
    parameter int ID_W  = 8,
    parameter int LAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pick,
    input  logic [ID_W-1:0]  issue_id,
    input  logic             done_vld,
    input  logic [ID_W-1:0]  done_id,
    output logic             busy,
    output logic             drop,
    output logic             rec_vld,
    output logic [ID_W-1:0]  rec_id,
    output logic [LAT_W-1:0] rec_lat
);
    localparam logic [LAT_W-1:0] LAT_MAX = '1;

    logic [ID_W-1:0]  tag;
    logic [LAT_W-1:0] lat;
    logic             take;
    logic             finish;

    assign take   = pick && !busy;
    assign drop   = pick && busy;
    assign finish = busy && done_vld && (done_id == tag);

    // Occupancy and tag of the outstanding pick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            tag  <= '0;
        end else if (finish) begin
            busy <= 1'b0;
        end else if (take) begin
            busy <= 1'b1;
            tag  <= issue_id;
        end
    end

    // Latency counter, saturating, starts at 1 on the pick edge
    always_ff @(posedge clk) begin
        if (!rst_n)                                 lat <= '0;
        else if (take)                              lat <= LAT_W'(1);
        else if (busy && !finish && lat != LAT_MAX) lat <= lat + LAT_W'(1);
    end

    // Completed-sample record, one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_vld <= 1'b0;
            rec_id  <= '0;
            rec_lat <= '0;
        end else begin
            rec_vld <= finish;
            if (finish) begin
                rec_id  <= tag;
                rec_lat <= lat;
            end
        end
    end
endmodule

// File: rtl/isam_satcnt.sv
// Saturating event counter with synchronous clear taking priority.
// Assumes inc is a single-cycle qualifier.
module isam_satcnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Clear first, then increment unless full
    always_ff @(posedge clk) begin
        if (!rst_n || clr)              count <= '0;
        else if (inc && count != '1)    count <= count + W'(1);
    end
endmodule

// File: rtl/interval_sampler.sv
// Interval sampler top: picks one issued operation every programmed
// number of issues, tracks it to completion, reports its latency and
// counts picks dropped because a sample was still outstanding.
// Assumes completions for the picked ID are unique per pick.
module interval_sampler #(
    parameter int ID_W         = 8,
    parameter int CNT_W        = 16,
    parameter int LAT_W        = 16,
    parameter int COLL_W       = 32,
    parameter int JIT_W        = 8,
    parameter int MIN_INTERVAL = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_vld,
    input  logic [ID_W-1:0]   issue_id,
    input  logic              done_vld,
    input  logic [ID_W-1:0]   done_id,
    input  logic [CNT_W-1:0]  cfg_interval,
    input  logic              cfg_jitter_en,
    input  logic              coll_clr,
    output logic              smp_vld,
    output logic [ID_W-1:0]   smp_id,
    output logic [LAT_W-1:0]  smp_lat,
    output logic [COLL_W-1:0] coll_cnt
);
    import isam_pkg::*;

    logic              pick;
    logic              drop;
    logic              trk_busy;
    logic [LFSR_W-1:0] lfsr_state;

    isam_lfsr u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (pick),
        .state (lfsr_state)
    );

    isam_countdown #(
        .CNT_W        (CNT_W),
        .JIT_W        (JIT_W),
        .MIN_INTERVAL (MIN_INTERVAL)
    ) u_cd (
        .clk           (clk),
        .rst_n         (rst_n),
        .issue_vld     (issue_vld),
        .cfg_interval  (cfg_interval),
        .cfg_jitter_en (cfg_jitter_en),
        .jitter        (lfsr_state[JIT_W-1:0]),
        .pick          (pick)
    );

    isam_tracker #(
        .ID_W  (ID_W),
        .LAT_W (LAT_W)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick     (pick),
        .issue_id (issue_id),
        .done_vld (done_vld),
        .done_id  (done_id),
        .busy     (trk_busy),
        .drop     (drop),
        .rec_vld  (smp_vld),
        .rec_id   (smp_id),
        .rec_lat  (smp_lat)
    );

    isam_satcnt #(
        .W (COLL_W)
    ) u_coll (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop),
        .clr   (coll_clr),
        .count (coll_cnt)
    );
endmodule

// File: rtl/interval_sampler_chk.sv
// Property checker for interval_sampler, attached by bind.
// Assumes it sees the top's ports plus the tracker occupancy flag.
module interval_sampler_chk #(
    parameter int LAT_W  = 16,
    parameter int COLL_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              coll_clr,
    input logic              smp_vld,
    input logic [LAT_W-1:0]  smp_lat,
    input logic [COLL_W-1:0] coll_cnt,
    input logic              trk_busy
);
    localparam logic [COLL_W-1:0] CMAX = '1;

    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (!smp_vld && coll_cnt == '0 && !trk_busy));

    assert_idle_on_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> !trk_busy);

    assert_no_drop_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trk_busy && !coll_clr) |=> (coll_cnt == $past(coll_cnt)));

    assert_coll_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !coll_clr |=> (coll_cnt == $past(coll_cnt) || coll_cnt == $past(coll_cnt) + 1'b1));

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> !smp_vld);

    assert_latency_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |-> (smp_lat != '0));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        coll_clr |=> (coll_cnt == '0));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_cnt == CMAX && !coll_clr) |=> (coll_cnt == CMAX));
endmodule

bind interval_sampler interval_sampler_chk #(
    .LAT_W  (LAT_W),
    .COLL_W (COLL_W)
) u_chk (.*);

// File: tb/interval_sampler_bench.sv
module interval_sampler_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [7:0]  issue_id = '0;
    logic        done_vld = 1'b0;
    logic [7:0]  done_id = '0;
    logic [15:0] cfg_interval = '0;
    logic        cfg_jitter_en = 1'b0;
    logic        coll_clr = 1'b0;
    logic        smp_vld;
    logic [7:0]  smp_id;
    logic [15:0] smp_lat;
    logic [31:0] coll_cnt;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // bench model state
    logic [16:0] m_cnt;
    logic [15:0] m_lfsr;
    logic        m_busy;
    logic [7:0]  m_tag;
    logic [15:0] m_lat;
    logic [31:0] m_coll;
    logic        m_svld;
    logic [7:0]  m_sid;
    logic [15:0] m_slat;

    // directed capture of sample ids
    logic [7:0]  seen_id [0:7];
    int          n_seen;

    interval_sampler u_interval_sampler (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] next_lfsr(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [16:0] reload_val(input logic [15:0] iv, input logic je,
                                               input logic [15:0] lf);
        logic [16:0] b;
        b = (iv == 0) ? 17'd16 : {1'b0, iv};
        return b + (je ? {9'd0, lf[7:0]} : 17'd0);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic model_reset();
        m_cnt = 17'd16; m_lfsr = 16'hACE1; m_busy = 0; m_tag = 0; m_lat = 0;
        m_coll = 0; m_svld = 0; m_sid = 0; m_slat = 0;
    endtask

    task automatic model_step();
        logic sel, fin;
        sel = issue_vld && (m_cnt <= 1);
        fin = m_busy && done_vld && (done_id == m_tag);
        m_svld = fin;
        if (fin) begin m_sid = m_tag; m_slat = m_lat; end
        if (coll_clr) m_coll = 0;
        else if (sel && m_busy && m_coll != 32'hFFFF_FFFF) m_coll = m_coll + 1;
        if (fin) m_busy = 0;
        else if (sel && !m_busy) begin m_busy = 1; m_tag = issue_id; m_lat = 1; end
        else if (m_busy && m_lat != 16'hFFFF) m_lat = m_lat + 1;
        if (sel) m_cnt = reload_val(cfg_interval, cfg_jitter_en, m_lfsr);
        else if (issue_vld) m_cnt = m_cnt - 1;
        if (sel) m_lfsr = next_lfsr(m_lfsr);
    endtask

    // one clock: inputs already set at negedge; update model; compare at next negedge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(smp_vld == m_svld, "R7 smp_vld", smp_vld, m_svld);
        if (m_svld) begin
            chk(smp_id == m_sid, "R7 smp_id", smp_id, m_sid);
            chk(smp_lat == m_slat, "R7 smp_lat", smp_lat, m_slat);
            if (n_seen < 8) seen_id[n_seen] = smp_id;
            n_seen++;
        end
        chk(coll_cnt == m_coll, "R6 coll_cnt", coll_cnt, m_coll);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; issue_vld = 0; done_vld = 0; coll_clr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
        n_seen = 0;
        chk(smp_vld == 0, "R1 smp_vld after reset", smp_vld, 0);
        chk(coll_cnt == 0, "R1 coll_cnt after reset", coll_cnt, 0);
    endtask

    // issue ids 0..n-1 one per cycle, completing the previous issue each cycle
    task automatic stream_complete(input int n);
        for (int i = 0; i < n; i++) begin
            issue_vld = 1; issue_id = 8'(i);
            done_vld = (i > 0); done_id = 8'(i - 1);
            cyc();
        end
        issue_vld = 0; done_vld = 1; done_id = 8'(n - 1);
        cyc();
        done_vld = 0;
        cyc();
    endtask

    initial begin
        // R1 + R3: interval 0 -> minimum 16, first pick is issue 15
        cfg_interval = 16'd5; cfg_jitter_en = 0;
        do_reset();
        cfg_interval = 16'd0;
        stream_complete(40);
        chk(n_seen == 2, "R3 sample count", n_seen, 2);
        chk(seen_id[0] == 8'd15, "R1 first pick id", seen_id[0], 15);
        chk(seen_id[1] == 8'd31, "R3 second pick id", seen_id[1], 31);

        // R2: spacing 3 after the first pick
        do_reset();
        cfg_interval = 16'd3;
        stream_complete(23);
        chk(seen_id[0] == 8'd15, "R2 pick id 0", seen_id[0], 15);
        chk(seen_id[1] == 8'd18, "R2 pick id 1", seen_id[1], 18);
        chk(seen_id[2] == 8'd21, "R2 pick id 2", seen_id[2], 21);

        // R4: jitter, first reload = 1 + 0xE1 = 226 -> next pick at issue 241
        do_reset();
        cfg_interval = 16'd1; cfg_jitter_en = 1;
        stream_complete(250);
        chk(n_seen == 2, "R4 sample count", n_seen, 2);
        chk(seen_id[1] == 8'd241, "R4 jittered pick id", seen_id[1], 241);
        cfg_jitter_en = 0;

        // R5/R6/R9: hold pick open, collisions, wrong-id completion, clear
        do_reset();
        cfg_interval = 16'd1;
        for (int i = 0; i < 16; i++) begin issue_vld = 1; issue_id = 8'(i); cyc(); end
        for (int i = 0; i < 5; i++) begin issue_vld = 1; issue_id = 8'(100 + i); cyc(); end
        chk(coll_cnt == 5, "R6 five drops", coll_cnt, 5);
        issue_vld = 0; done_vld = 1; done_id = 8'd101; cyc();
        done_vld = 0; cyc();
        chk(smp_vld == 0, "R5 wrong id ignored", smp_vld, 0);
        // completion and new pick in same cycle: pick still dropped (R6)
        issue_vld = 1; issue_id = 8'd200; done_vld = 1; done_id = 8'd15; cyc();
        issue_vld = 0; done_vld = 0;
        chk(smp_vld == 1 && smp_id == 8'd15, "R5 right id completes", smp_id, 15);
        chk(smp_lat == 16'd8, "R7 latency count", smp_lat, 8);
        chk(coll_cnt == 6, "R6 drop at completion", coll_cnt, 6);
        cyc();
        chk(smp_vld == 0, "R7 single pulse", smp_vld, 0);
        coll_clr = 1; issue_vld = 1; issue_id = 8'd1; cyc();
        issue_vld = 1; issue_id = 8'd2; cyc();
        coll_clr = 0; issue_vld = 0;
        chk(coll_cnt == 0, "R9 clear priority", coll_cnt, 0);
        // now busy with id 1; complete it
        done_vld = 1; done_id = 8'd1; cyc(); done_vld = 0; cyc();

        // R8: latency saturation
        cfg_interval = 16'd1;
        issue_vld = 1; issue_id = 8'd77; cyc(); issue_vld = 0;
        for (int i = 0; i < 65600; i++) cyc();
        done_vld = 1; done_id = 8'd77; cyc(); done_vld = 0;
        chk(smp_vld == 1, "R8 record present", smp_vld, 1);
        chk(smp_lat == 16'hFFFF, "R8 latency saturates", smp_lat, 65535);
        cyc();

        // random phases (all requirements via model)
        void'($urandom(32'd1234));
        begin
            int idn;
            idn = 0;
            for (int ph = 0; ph < 6; ph++) begin
                cfg_interval = 16'($urandom_range(0, 6));
                cfg_jitter_en = 1'($urandom_range(0, 1));
                for (int i = 0; i < 3000; i++) begin
                    issue_vld = ($urandom_range(0, 99) < 60);
                    issue_id = 8'(idn);
                    if (issue_vld) idn++;
                    done_vld = ($urandom_range(0, 99) < 25);
                    done_id = (m_busy && $urandom_range(0, 1) == 1) ? m_tag : 8'(idn + 128);
                    coll_clr = ($urandom_range(0, 499) == 0);
                    cyc();
                end
            end
        end
        issue_vld = 0; done_vld = 0; coll_clr = 0;
        cyc();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule